// File: doc/BRIEF.md
# Coherence False Sharing Detector

This block sits beside one private L1 data cache and watches two streams: the words the local core touches, and the invalidation snoops that arrive from other caches. For each resident line it keeps a bit vector with one bit per 4-byte word. Each local access sets the bit of the word it touches. An invalidation snoop carries the set of words the remote requester actually wants. Before the line is dropped, the block compares that remote set with the local vector. If the two sets share no word and the local core had touched the line, the invalidation is false. The line address and the remote set are then recorded in a small map of falsely invalidated lines.

Each later local miss is looked up in that map. One cycle after the miss, a strobe reports whether the miss was caused by false sharing, together with the stored remote word set, and the map entry is retired. A small table of saturating counters keeps a running count of false invalidations per line address. A read port exposes this table.

The cache supplies a slot index (its set and way) with every access, fill and snoop. The map and the histogram hold line addresses, meaning byte address bits above the 64-byte offset.

Top module: `false_share_monitor`

## Requirements
- R1: A local access (`acc_valid`) sets bit `acc_word` of the word vector of slot `acc_slot`. Bit n stands for the 4-byte word at byte offset 4n of the 64-byte line.
- R2: A fill of a slot clears that slot's vector. An invalidation of a slot also clears that slot's vector.
- R3: An invalidation is false exactly when the slot's stored vector is non-zero and its bitwise AND with `inv_rvec` is zero. An overlapping set is not false, and neither is an untouched line.
- R4: A false invalidation records `inv_line` and `inv_rvec` in the map of falsely invalidated lines.
- R5: `cls_valid` is high exactly in the cycle after `miss_valid`. With it, `cls_false` is 1 if `miss_line` was in the map, and `cls_rvec` carries the stored remote vector. When the line was not in the map, `cls_rvec` is zero.
- R6: A miss that hits the map retires that entry, so a second miss to the same line is not classified as false.
- R7: A false invalidation for a line already in the map overwrites the stored vector of that entry and never creates a second entry.
- R8: The map holds 8 lines. A new line arriving when the map is full evicts the line that was recorded earliest.
- R9: Each false invalidation adds one to the histogram counter of its line. A line without a counter is given the next entry in round-robin order (0, 1, … 15, then 0 again), starting at a count of 1. `hist_sel` reads out `hist_valid`, `hist_line` and `hist_count` of one entry.
- R10: A histogram counter stops at 65535 and does not wrap.
- R11: Several events can fall on one edge. An invalidation is judged against the vector as stored before that edge. A clear wins over an access to the same slot. A map retirement is applied before an insertion, so a line retired and falsely invalidated on one edge stays in the map with the new vector.
- R12: After reset `cls_valid` is 0, every histogram entry reads invalid, and the map is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Local core touches a word |
| acc_slot | input | 4 | Slot of the touched line |
| acc_word | input | 4 | Word index within the line |
| fill_valid | input | 1 | A line is filled into a slot |
| fill_slot | input | 4 | Slot being filled |
| inv_valid | input | 1 | Invalidation snoop hits a resident line |
| inv_slot | input | 4 | Slot hit by the snoop |
| inv_line | input | 26 | Line address of the snooped line |
| inv_rvec | input | 16 | Words wanted by the remote requester |
| miss_valid | input | 1 | Local miss event |
| miss_line | input | 26 | Line address of the miss |
| cls_valid | output | 1 | Miss classification strobe |
| cls_false | output | 1 | Miss was caused by false sharing |
| cls_rvec | output | 16 | Remote vector stored for the missed line |
| hist_sel | input | 4 | Histogram entry to read |
| hist_valid | output | 1 | Selected entry is in use |
| hist_line | output | 26 | Line address of the selected entry |
| hist_count | output | 16 | False invalidation count of the selected entry |

## Verification
Directed sequences cover these cases:
- Disjoint word sets, which must be judged false, against overlapping sets and untouched lines, which must not be.
- A fill or invalidation between touching a line and snooping it, which shows that the vector was cleared.
- Repeated snoops to one line, which tell an in-place update from a duplicate entry.
- A run of nine distinct false lines, which shows which line the full map gives up.
- Access and snoop to the same slot on one edge, which shows the ordering of judge, clear and set.

Seeded random traffic over a small pool of lines and slots mixes misses with insertions, so retirements, refills and evictions interleave. A long alternating snoop run on one line drives its counter into saturation.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

    localparam int LINE_BYTES = 64;
    localparam int WORD_BYTES = 4;
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int WIDX_W     = $clog2(WORDS);
    localparam int ADDR_W     = 32;
    localparam int LINE_AW    = ADDR_W - $clog2(LINE_BYTES);
    localparam int HCNT_W     = 16;

    typedef logic [WORDS-1:0]   wvec_t;
    typedef logic [LINE_AW-1:0] line_t;
    typedef logic [HCNT_W-1:0]  hcnt_t;

    typedef struct packed {
        logic  valid;
        line_t line;
        wvec_t rvec;
    } map_ent_t;

    typedef struct packed {
        logic  valid;
        line_t line;
        hcnt_t count;
    } hist_ent_t;

    // touched locally, and no word in common with the remote request
    function automatic logic judge_false(wvec_t local_v, wvec_t remote_v);
        return (local_v != '0) && ((local_v & remote_v) == '0);
    endfunction

    function automatic hcnt_t sat_inc(hcnt_t c);
        return (c == '1) ? c : c + hcnt_t'(1);
    endfunction

endpackage

// File: rtl/fsd_access_track.sv
module fsd_access_track
    import fsd_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [SLOT_W-1:0] acc_slot,
    input  logic [WIDX_W-1:0] acc_word,
    input  logic              fill_valid,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic              inv_valid,
    input  logic [SLOT_W-1:0] inv_slot,
    output wvec_t             inv_local
);

    wvec_t vec [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic clr_s, set_s;
        assign clr_s = (fill_valid && fill_slot == SLOT_W'(s)) ||
                       (inv_valid  && inv_slot  == SLOT_W'(s));
        assign set_s = acc_valid && acc_slot == SLOT_W'(s);

        always_ff @(posedge clk) begin
            if (rst) begin
                vec[s] <= '0;
            end else if (clr_s) begin
                vec[s] <= '0;
            end else if (set_s) begin
                vec[s][acc_word] <= 1'b1;
            end
        end
    end

    assign inv_local = vec[inv_slot];

    // R1: an access with no clear to the same slot leaves its bit set
    a_r1_bit_set: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !(fill_valid && fill_slot == acc_slot)
                   && !(inv_valid && inv_slot == acc_slot))
        |=> vec[$past(acc_slot)][$past(acc_word)]);

    // R2: fills and invalidations leave an empty vector
    a_r2_fill_clear: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> vec[$past(fill_slot)] == '0);

    a_r2_inv_clear: assert property (@(posedge clk) disable iff (rst)
        inv_valid |=> vec[$past(inv_slot)] == '0);

endmodule

// File: rtl/fsd_fs_map.sv
module fsd_fs_map
    import fsd_pkg::*;
#(
    parameter int DEPTH   = 8,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  line_t            lk_line,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output wvec_t            lk_rvec,
    input  logic             rm_en,
    input  logic [IDX_W-1:0] rm_idx,
    input  logic             ins_en,
    input  line_t            ins_line,
    input  wvec_t            ins_rvec
);

    // entries kept packed towards index 0; index 0 is the oldest
    map_ent_t          ent [DEPTH];
    map_ent_t          nxt [DEPTH];
    logic [CNT_W-1:0]  cnt, ncnt;
    logic [DEPTH-1:0]  vmask;

    always_comb begin
        lk_hit  = 1'b0;
        lk_idx  = '0;
        lk_rvec = '0;
        for (int i = 0; i < DEPTH; i++) begin
            vmask[i] = ent[i].valid;
            if (ent[i].valid && ent[i].line == lk_line) begin
                lk_hit  = 1'b1;
                lk_idx  = IDX_W'(i);
                lk_rvec = ent[i].rvec;
            end
        end
    end

    always_comb begin
        logic             dup;
        logic [IDX_W-1:0] didx;
        nxt  = ent;
        ncnt = cnt;
        dup  = 1'b0;
        didx = '0;
        // retirement first: close the gap
        if (rm_en) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= int'(rm_idx)) nxt[i] = ent[i+1];
            end
            nxt[DEPTH-1] = '0;
            ncnt         = cnt - CNT_W'(1);
        end
        if (ins_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (nxt[i].valid && nxt[i].line == ins_line) begin
                    dup  = 1'b1;
                    didx = IDX_W'(i);
                end
            end
            if (dup) begin
                nxt[didx].rvec = ins_rvec;
            end else if (ncnt == CNT_W'(DEPTH)) begin
                for (int i = 0; i < DEPTH - 1; i++) nxt[i] = nxt[i+1];
                nxt[DEPTH-1] = '{valid: 1'b1, line: ins_line, rvec: ins_rvec};
            end else begin
                nxt[ncnt[IDX_W-1:0]] = '{valid: 1'b1, line: ins_line, rvec: ins_rvec};
                ncnt = ncnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
            cnt <= '0;
        end else begin
            ent <= nxt;
            cnt <= ncnt;
        end
    end

    // R8: occupancy stays within depth and matches the valid entries
    a_r8_bound: assert property (@(posedge clk) disable iff (rst)
        (cnt <= CNT_W'(DEPTH)) && ($countones(vmask) == int'(cnt)));

    // R7: no line is held twice
    for (genvar i = 0; i < DEPTH; i++) begin : g_ua
        for (genvar j = i + 1; j < DEPTH; j++) begin : g_ub
            a_r7_unique: assert property (@(posedge clk) disable iff (rst)
                !(ent[i].valid && ent[j].valid && ent[i].line == ent[j].line));
        end
    end

endmodule

// File: rtl/fsd_histogram.sv
module fsd_histogram
    import fsd_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_en,
    input  line_t            ev_line,
    input  logic [IDX_W-1:0] rd_sel,
    output logic             rd_valid,
    output line_t            rd_line,
    output hcnt_t            rd_count
);

    hist_ent_t        ent [DEPTH];
    logic [IDX_W-1:0] ptr;
    logic             hit;
    logic [IDX_W-1:0] hidx;

    always_comb begin
        hit  = 1'b0;
        hidx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent[i].valid && ent[i].line == ev_line) begin
                hit  = 1'b1;
                hidx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
            ptr <= '0;
        end else if (ev_en) begin
            if (hit) begin
                ent[hidx].count <= sat_inc(ent[hidx].count);
            end else begin
                ent[ptr] <= '{valid: 1'b1, line: ev_line, count: hcnt_t'(1)};
                ptr      <= (ptr == IDX_W'(DEPTH - 1)) ? '0 : ptr + IDX_W'(1);
            end
        end
    end

    assign rd_valid = ent[rd_sel].valid;
    assign rd_line  = ent[rd_sel].line;
    assign rd_count = ent[rd_sel].count;

    // R10: a full counter keeps its value unless the entry is reallocated
    for (genvar i = 0; i < DEPTH; i++) begin : g_sat
        a_r10_saturate: assert property (@(posedge clk) disable iff (rst)
            (ent[i].valid && ent[i].count == '1 && !(ev_en && !hit && ptr == IDX_W'(i)))
            |=> ent[i].count == '1);
    end

endmodule

// File: rtl/false_share_monitor.sv
module false_share_monitor
    import fsd_pkg::*;
#(
    parameter int NUM_SLOTS  = 16,
    parameter int MAP_DEPTH  = 8,
    parameter int HIST_DEPTH = 16,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int MIDX_W    = $clog2(MAP_DEPTH),
    localparam int HIDX_W    = $clog2(HIST_DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_valid,
    input  logic [SLOT_W-1:0]   acc_slot,
    input  logic [WIDX_W-1:0]   acc_word,
    input  logic                fill_valid,
    input  logic [SLOT_W-1:0]   fill_slot,
    input  logic                inv_valid,
    input  logic [SLOT_W-1:0]   inv_slot,
    input  logic [LINE_AW-1:0]  inv_line,
    input  logic [WORDS-1:0]    inv_rvec,
    input  logic                miss_valid,
    input  logic [LINE_AW-1:0]  miss_line,
    output logic                cls_valid,
    output logic                cls_false,
    output logic [WORDS-1:0]    cls_rvec,
    input  logic [HIDX_W-1:0]   hist_sel,
    output logic                hist_valid,
    output logic [LINE_AW-1:0]  hist_line,
    output logic [HCNT_W-1:0]   hist_count
);

    wvec_t             inv_local;
    logic              false_inv;
    logic              lk_hit;
    logic [MIDX_W-1:0] lk_idx;
    wvec_t             lk_rvec;
    logic              retire;

    fsd_access_track #(.NUM_SLOTS(NUM_SLOTS)) u_track (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (acc_valid),
        .acc_slot   (acc_slot),
        .acc_word   (acc_word),
        .fill_valid (fill_valid),
        .fill_slot  (fill_slot),
        .inv_valid  (inv_valid),
        .inv_slot   (inv_slot),
        .inv_local  (inv_local)
    );

    assign false_inv = inv_valid && judge_false(inv_local, inv_rvec);
    assign retire    = miss_valid && lk_hit;

    fsd_fs_map #(.DEPTH(MAP_DEPTH)) u_map (
        .clk      (clk),
        .rst      (rst),
        .lk_line  (miss_line),
        .lk_hit   (lk_hit),
        .lk_idx   (lk_idx),
        .lk_rvec  (lk_rvec),
        .rm_en    (retire),
        .rm_idx   (lk_idx),
        .ins_en   (false_inv),
        .ins_line (inv_line),
        .ins_rvec (inv_rvec)
    );

    fsd_histogram #(.DEPTH(HIST_DEPTH)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .ev_en    (false_inv),
        .ev_line  (inv_line),
        .rd_sel   (hist_sel),
        .rd_valid (hist_valid),
        .rd_line  (hist_line),
        .rd_count (hist_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_valid <= 1'b0;
            cls_false <= 1'b0;
            cls_rvec  <= '0;
        end else begin
            cls_valid <= miss_valid;
            cls_false <= retire;
            cls_rvec  <= retire ? lk_rvec : '0;
        end
    end

    // R5: strobe follows each miss by exactly one cycle
    a_r5_strobe: assert property (@(posedge clk) disable iff (rst)
        miss_valid |=> cls_valid);
    a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
        !miss_valid |=> !cls_valid);
    // R12: reset leaves the strobe low
    a_r12_reset_idle: assert property (@(posedge clk)
        rst |=> !cls_valid);

endmodule

// File: tb/test_false_share_monitor.sv
module test_false_share_monitor;
    import fsd_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              acc_valid = 0, fill_valid = 0, inv_valid = 0, miss_valid = 0;
    logic [3:0]        acc_slot = 0, fill_slot = 0, inv_slot = 0, hist_sel = 0;
    logic [WIDX_W-1:0] acc_word = 0;
    line_t             inv_line = 0, miss_line = 0;
    wvec_t             inv_rvec = 0;
    logic              cls_valid, cls_false, hist_valid;
    wvec_t             cls_rvec;
    line_t             hist_line;
    hcnt_t             hist_count;

    false_share_monitor i_false_share_monitor (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_slot(acc_slot), .acc_word(acc_word),
        .fill_valid(fill_valid), .fill_slot(fill_slot),
        .inv_valid(inv_valid), .inv_slot(inv_slot), .inv_line(inv_line), .inv_rvec(inv_rvec),
        .miss_valid(miss_valid), .miss_line(miss_line),
        .cls_valid(cls_valid), .cls_false(cls_false), .cls_rvec(cls_rvec),
        .hist_sel(hist_sel), .hist_valid(hist_valid), .hist_line(hist_line), .hist_count(hist_count)
    );

    int n_chk = 0, n_fail = 0;

    // reference state, built from the requirements
    wvec_t       m_vec  [16];
    line_t       m_mline[8];
    wvec_t       m_mrv  [8];
    int          m_mcnt;
    bit          m_hval [16];
    line_t       m_hline[16];
    int unsigned m_hcnt [16];
    int          m_hptr;

    task automatic chk(string tag, string what, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic step(string tag, bit av, int as, int aw, bit fv, int fs,
                        bit iv, int is, line_t il, wvec_t ir, bit mv, line_t ml);
        bit    e_false, fi, dup;
        wvec_t e_rv;
        int    hidx, di, hi;
        acc_valid = av;  acc_slot = 4'(as); acc_word = 4'(aw);
        fill_valid = fv; fill_slot = 4'(fs);
        inv_valid = iv;  inv_slot = 4'(is); inv_line = il; inv_rvec = ir;
        miss_valid = mv; miss_line = ml;
        e_false = 0; e_rv = 0; hidx = -1;
        if (mv)
            for (int i = 0; i < m_mcnt; i++)
                if (m_mline[i] == ml) begin e_false = 1; e_rv = m_mrv[i]; hidx = i; end
        fi = iv && (m_vec[is] != 0) && ((m_vec[is] & ir) == 0);
        @(posedge clk);
        if (av) m_vec[as][aw] = 1'b1;
        if (fv) m_vec[fs] = '0;
        if (iv) m_vec[is] = '0;
        if (hidx >= 0) begin
            for (int i = hidx; i < m_mcnt - 1; i++) begin
                m_mline[i] = m_mline[i+1]; m_mrv[i] = m_mrv[i+1];
            end
            m_mcnt--;
        end
        if (fi) begin
            dup = 0; di = 0;
            for (int i = 0; i < m_mcnt; i++) if (m_mline[i] == il) begin dup = 1; di = i; end
            if (dup) m_mrv[di] = ir;
            else begin
                if (m_mcnt == 8) begin
                    for (int i = 0; i < 7; i++) begin
                        m_mline[i] = m_mline[i+1]; m_mrv[i] = m_mrv[i+1];
                    end
                    m_mcnt = 7;
                end
                m_mline[m_mcnt] = il; m_mrv[m_mcnt] = ir; m_mcnt++;
            end
            hi = -1;
            for (int i = 0; i < 16; i++) if (m_hval[i] && m_hline[i] == il) hi = i;
            if (hi >= 0) begin
                if (m_hcnt[hi] < 65535) m_hcnt[hi]++;
            end else begin
                m_hval[m_hptr] = 1; m_hline[m_hptr] = il; m_hcnt[m_hptr] = 1;
                m_hptr = (m_hptr + 1) % 16;
            end
        end
        @(negedge clk);
        acc_valid = 0; fill_valid = 0; inv_valid = 0; miss_valid = 0;
        chk(tag, "cls_valid", cls_valid, mv);
        if (mv) begin
            chk(tag, "cls_false", cls_false, e_false);
            chk(tag, "cls_rvec", cls_rvec, e_rv);
        end
    endtask

    task automatic acc(string t, int s, int w);   step(t, 1, s, w, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic fill(string t, int s);         step(t, 0, 0, 0, 1, s, 0, 0, 0, 0, 0, 0); endtask
    task automatic inv(string t, int s, line_t l, wvec_t r); step(t, 0, 0, 0, 0, 0, 1, s, l, r, 0, 0); endtask
    task automatic miss(string t, line_t l);      step(t, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, l); endtask

    task automatic check_hist(string tag);
        for (int i = 0; i < 16; i++) begin
            hist_sel = 4'(i);
            #1;
            chk(tag, "hist_valid", hist_valid, m_hval[i]);
            if (m_hval[i]) begin
                chk(tag, "hist_line", hist_line, m_hline[i]);
                chk(tag, "hist_count", hist_count, m_hcnt[i]);
            end
        end
    endtask

    initial begin
        #(2_000_000ns);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        line_t pl;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin m_vec[i] = 0; m_hval[i] = 0; m_hline[i] = 0; m_hcnt[i] = 0; end
        for (int i = 0; i < 8; i++) begin m_mline[i] = 0; m_mrv[i] = 0; end
        m_mcnt = 0; m_hptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R12: reset state
        chk("R12", "cls_valid", cls_valid, 0);
        check_hist("R12");
        miss("R12", 26'h100);

        // R1 R3 R4 R5: disjoint sets are false; stored vector returned
        acc("R1", 0, 3);
        inv("R3", 0, 26'h101, 16'h0020);
        miss("R5", 26'h101);
        chk("R4", "cls_rvec literal", cls_rvec, 16'h0020);
        // R6: retired after one classified miss
        miss("R6", 26'h101);
        chk("R6", "cls_false literal", cls_false, 0);
        // R3: overlapping set is not false
        acc("R3", 1, 2);
        inv("R3", 1, 26'h102, 16'h0004);
        miss("R3", 26'h102);
        // R3: untouched line is not false
        inv("R3", 2, 26'h103, 16'h0001);
        miss("R3", 26'h103);
        // R2: fill clears
        acc("R2", 3, 1);
        fill("R2", 3);
        inv("R2", 3, 26'h104, 16'h0010);
        miss("R2", 26'h104);
        // R2: invalidation clears
        acc("R2", 4, 1);
        inv("R2", 4, 26'h105, 16'h0080);
        inv("R2", 4, 26'h106, 16'h0080);
        miss("R2", 26'h106);
        // R7: repeat on same line updates in place
        acc("R7", 5, 0);
        inv("R7", 5, 26'h107, 16'h0002);
        acc("R7", 5, 0);
        inv("R7", 5, 26'h107, 16'h0004);
        miss("R7", 26'h107);
        chk("R7", "cls_rvec literal", cls_rvec, 16'h0004);
        miss("R7", 26'h107);
        // R11: same-edge access and snoop judge the old vector; clear wins
        step("R11", 1, 7, 3, 0, 0, 1, 7, 26'h108, 16'h0001, 0, 0);
        inv("R11", 7, 26'h109, 16'h0001);
        miss("R11", 26'h109);
        // R11: retirement and re-insertion of one line on one edge
        acc("R11", 8, 5);
        inv("R11", 8, 26'h10A, 16'h0001);
        acc("R11", 8, 5);
        step("R11", 0, 0, 0, 0, 0, 1, 8, 26'h10A, 16'h0100, 1, 26'h10A);
        miss("R11", 26'h10A);
        chk("R11", "cls_rvec literal", cls_rvec, 16'h0100);
        // R8: nine new lines overflow the map
        for (int k = 0; k < 9; k++) begin
            acc("R8", 6, 0);
            inv("R8", 6, 26'h200 + 26'(k), 16'h0002);
        end
        miss("R8", 26'h200);
        miss("R8", 26'h201);
        chk("R8", "cls_false literal", cls_false, 1);
        check_hist("R9");

        // seeded random traffic
        for (int n = 0; n < 3000; n++) begin
            pl = 26'h300 + 26'($urandom % 12);
            step("R9", ($urandom % 2) == 1, $urandom % 8, $urandom % 16,
                 ($urandom % 8) == 0, $urandom % 8,
                 ($urandom % 3) == 0, $urandom % 8, pl,
                 (($urandom % 2) == 1) ? wvec_t'(1 << ($urandom % 16)) : wvec_t'($urandom),
                 ($urandom % 3) == 0, 26'h300 + 26'($urandom % 12));
        end
        check_hist("R9");

        // R10: counter saturation on one line
        acc("R10", 9, 0);
        for (int k = 0; k < 65540; k++) begin
            if (k % 2 == 0) step("R10", 1, 10, 0, 0, 0, 1, 9, 26'h3FF, 16'h8000, 0, 0);
            else            step("R10", 1, 9, 0, 0, 0, 1, 10, 26'h3FF, 16'h8000, 0, 0);
        end
        check_hist("R10");
        miss("R10", 26'h3FF);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule